// File: doc/BRIEF.md
# Zero-Cross Status and Interrupt Logic

This block turns the raw digital output of an analog zero-cross detector into a status bit that software can read and into an interrupt. The comparator level is high while the detector's current sink is active. It passes through a synchronizer and a hold stage that the module enable gates. A polarity control then inverts it to form the status bit. Edge detectors watch that status bit, so the polarity setting decides which physical transition counts as a rising edge.

A qualified edge sets a sticky flag. A rising edge qualifies when the rising-edge enable is set, and a falling edge qualifies when the falling-edge enable is set. The flag stays set until software clears it with a one-cycle strobe. An interrupt request goes out only while the flag, the peripheral interrupt enable, the peripheral gate and the global gate are all high.

Two cases need care. Toggling the polarity flips the held status, so it can raise the flag even while the module is disabled. A clear that arrives together with a new qualified edge leaves the flag set.

Top module: `zx_status_irq`

## Requirements
- R1: With polarity 0 and the module enabled, `status_o` equals the synchronized comparator level: 1 means the sink is active.
- R2: With polarity 1, `status_o` is the inverse of the held comparator level: 1 means the source is active.
- R3: A comparator change, held stable while the module is enabled, appears on `status_o` after the third rising clock edge.
- R4: On the edge after `status_o` changes, the flag is set for a 0-to-1 change only if the rising-edge enable is 1, and for a 1-to-0 change only if the falling-edge enable is 1. An unqualified edge leaves the flag unchanged.
- R5: A polarity write flips `status_o` on the edge that applies it. This counts as an edge for R4 even when the module enable is 0.
- R6: While the module enable is 0, comparator activity does not change `status_o`.
- R7: The flag stays set until `flag_clr_i` is sampled high with no qualified edge in that cycle. The flag is then 0 after that edge.
- R8: When `flag_clr_i` is high in the same cycle as a qualified edge, the flag is 1 after that edge.
- R9: `irq_o` is 1 exactly when the flag, `int_en_i`, `periph_gate_i` and `global_gate_i` are all 1.
- R10: After synchronous reset, `status_o`, `flag_o` and `irq_o` are 0, every control bit is 0, and the first cycle after reset detects no edge.
- R11: When `ctrl_we_i` is high at a rising edge, `ctrl_wdata_i` is loaded at that edge. The fields are bit 0 module enable, bit 1 polarity, bit 2 rising-edge enable and bit 3 falling-edge enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw_i | input | 1 | Asynchronous comparator level, high while the sink is active |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write data: bit0 enable, bit1 polarity, bit2 rise enable, bit3 fall enable |
| int_en_i | input | 1 | Peripheral interrupt enable |
| periph_gate_i | input | 1 | Peripheral interrupt gate |
| global_gate_i | input | 1 | Global interrupt gate |
| flag_clr_i | input | 1 | Software flag-clear strobe, one cycle |
| status_o | output | 1 | Polarity-adjusted status bit |
| flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The assertions assume three things about the inputs. All of them are sampled synchronously, the clear is a plain level that the logic looks at only on clock edges, and the comparator input is the only asynchronous signal. The bench keeps to these assumptions by changing every input only on the falling clock edge. It holds the comparator stable for several cycles around the directed latency checks, and in the random phase it lets the comparator toggle freely, because the synchronizer absorbs that activity. The random phase mixes rare control writes that toggle the enable and the polarity with frequent clears and gate changes. This makes clear-versus-edge collisions and polarity edges while disabled occur many times.

// File: rtl/zx_pkg.sv
// Package: shared types for the zero-cross status and interrupt block.
// Assumes the control word is four bits wide, with the enable in the LSB.
package zx_pkg;
    localparam int CTRL_W = 4;

    // Control register layout. A packed struct lists its MSB first:
    // fall_en is bit 3, rise_en bit 2, pol bit 1, en bit 0.
    typedef struct packed {
        logic fall_en;
        logic rise_en;
        logic pol;
        logic en;
    } zx_ctrl_t;
endpackage

// File: rtl/zx_ctrl_reg.sv
// Module: control register loaded from the write port.
// A write takes effect on the clock edge that samples ctrl_we.
// Reset clears every field to 0.
module zx_ctrl_reg
    import zx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output zx_ctrl_t          ctrl_q
);
    // Load the control fields on a write and clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we)
            ctrl_q <= zx_ctrl_t'(wdata);
    end
endmodule

// File: rtl/zx_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2. Reset clears every stage to 0.
module zx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // The first stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= 1'b0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Each later stage re-registers the stage before it.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= 1'b0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/zx_status.sv
// Module: status path and edge detection.
// The held level follows the synchronized comparator only while enabled.
// The polarity is applied after the hold, so a polarity change is visible
// even while disabled. The previous status is registered, and an edge is
// the difference between the current status and that registered value.
module zx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_sync,
    input  logic en,
    input  logic pol,
    output logic status,
    output logic rise_ev,
    output logic fall_ev
);
    logic held_q;
    logic prev_q;

    // Track the synchronized level while enabled, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)  held_q <= 1'b0;
        else if (en) held_q <= lvl_sync;
    end

    // Apply the polarity to the held level.
    always_comb begin
        status = held_q ^ pol;
    end

    // Remember the status of the last cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= status;
    end

    // Decode the direction of a status change.
    always_comb begin
        rise_ev = status & ~prev_q;
        fall_ev = ~status & prev_q;
    end
endmodule

// File: rtl/zx_flag.sv
// Module: sticky interrupt flag and request gating.
// Setting has priority over the software clear within the same cycle.
// The request is combinational from the flag and the three gates.
module zx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_ev,
    input  logic fall_ev,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    input  logic int_en,
    input  logic periph_gate,
    input  logic global_gate,
    output logic edge_hit,
    output logic flag_q,
    output logic irq
);
    // Qualify each detected edge with its enable.
    always_comb begin
        edge_hit = (rise_ev & rise_en) | (fall_ev & fall_en);
    end

    // Set on a qualified edge, otherwise clear on the strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (edge_hit) flag_q <= 1'b1;
        else if (clr)      flag_q <= 1'b0;
    end

    // Request the interrupt only when every gate is open.
    always_comb begin
        irq = flag_q & int_en & periph_gate & global_gate;
    end
endmodule

// File: rtl/zx_status_irq.sv
// Module: top of the zero-cross status and interrupt block.
// Assumes one clock, and cmp_raw_i as the only asynchronous input.
// SYNC_STAGES sets the depth of the comparator synchronizer.
module zx_status_irq
    import zx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              int_en_i,
    input  logic              periph_gate_i,
    input  logic              global_gate_i,
    input  logic              flag_clr_i,
    output logic              status_o,
    output logic              flag_o,
    output logic              irq_o
);
    zx_ctrl_t ctrl_q;
    logic     lvl_sync;
    logic     rise_ev;
    logic     fall_ev;
    logic     edge_hit;

    zx_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we_i),
        .wdata  (ctrl_wdata_i),
        .ctrl_q (ctrl_q)
    );

    zx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_raw_i),
        .q     (lvl_sync)
    );

    zx_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_sync (lvl_sync),
        .en       (ctrl_q.en),
        .pol      (ctrl_q.pol),
        .status   (status_o),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    zx_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_ev     (rise_ev),
        .fall_ev     (fall_ev),
        .rise_en     (ctrl_q.rise_en),
        .fall_en     (ctrl_q.fall_en),
        .clr         (flag_clr_i),
        .int_en      (int_en_i),
        .periph_gate (periph_gate_i),
        .global_gate (global_gate_i),
        .edge_hit    (edge_hit),
        .flag_q      (flag_o),
        .irq         (irq_o)
    );
endmodule

// File: rtl/zx_status_irq_chk.sv
// Module: assertion checker bound to zx_status_irq.
// It sees the ports and the internal enable, polarity and edge-hit signals.
module zx_status_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic status,
    input logic flag,
    input logic irq,
    input logic clr,
    input logic int_en,
    input logic en,
    input logic pol,
    input logic edge_hit
);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R8
    clr_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && edge_hit) |=> flag);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && int_en));

    // R6
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(status) && $stable(pol)) |-> $past(en));

    // R4
    flag_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(status) != $past(status, 2)));
endmodule

bind zx_status_irq zx_status_irq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status_o),
    .flag     (flag_o),
    .irq      (irq_o),
    .clr      (flag_clr_i),
    .int_en   (int_en_i),
    .en       (ctrl_q.en),
    .pol      (ctrl_q.pol),
    .edge_hit (edge_hit)
);

// File: tb/sim_zx_status_irq.sv
`timescale 1ns/1ps
module sim_zx_status_irq;
    localparam real HALF = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp = 1'b0;
    logic       we = 1'b0;
    logic [3:0] wd = 4'd0;
    logic       ie = 1'b0, pg = 1'b0, gg = 1'b0, clr = 1'b0;
    logic       st, fl, irq;

    int checks = 0;
    int fails  = 0;

    always #(HALF) clk = ~clk;

    zx_status_irq u0 (
        .clk(clk), .rst_n(rst_n), .cmp_raw_i(cmp), .ctrl_we_i(we),
        .ctrl_wdata_i(wd), .int_en_i(ie), .periph_gate_i(pg),
        .global_gate_i(gg), .flag_clr_i(clr),
        .status_o(st), .flag_o(fl), .irq_o(irq)
    );

    // Requirement-level reference model, updated on each rising edge.
    logic m_s1, m_s2, m_held, m_prev, m_flag;
    logic m_en, m_pol, m_re, m_fe;

    function automatic logic f_status(input logic held, input logic pol);
        return held ^ pol;
    endfunction

    function automatic logic f_irq(input logic f, input logic a, input logic b, input logic c);
        return f & a & b & c;
    endfunction

    always @(posedge clk) begin
        logic s, r, f;
        if (!rst_n) begin
            {m_s1, m_s2, m_held, m_prev, m_flag} = '0;
            {m_en, m_pol, m_re, m_fe} = '0;
        end else begin
            s = f_status(m_held, m_pol);
            r = s & ~m_prev;
            f = ~s & m_prev;
            if ((r & m_re) | (f & m_fe)) m_flag = 1'b1;
            else if (clr)                m_flag = 1'b0;
            m_prev = s;
            if (m_en) m_held = m_s2;
            m_s2 = m_s1;
            m_s1 = cmp;
            if (we) {m_fe, m_re, m_pol, m_en} = wd;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] v);
        we = 1'b1; wd = v;
        tick();
        we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        rst_n = 1'b1;
        tick();
        // R10: reset state
        chk(st, 1'b0, "R10 status");
        chk(fl, 1'b0, "R10 flag");
        chk(irq, 1'b0, "R10 irq");
        ie = 1; pg = 1; gg = 1;

        // R5 / R11: polarity and rise enable written with the module off
        wr(4'b0110);
        chk(st, 1'b1, "R5 status flips with polarity");
        chk(fl, 1'b0, "R5 flag not yet set");
        tick();
        chk(fl, 1'b1, "R5 polarity edge sets flag while disabled");
        chk(irq, 1'b1, "R9 all gates open");
        ie = 0;
        #1 chk(irq, 1'b0, "R9 interrupt enable closed");
        ie = 1; gg = 0;
        #1 chk(irq, 1'b0, "R9 global gate closed");
        gg = 1;

        // R7: flag stays set until cleared
        tick(3);
        chk(fl, 1'b1, "R7 flag sticky");
        clr = 1; tick(); clr = 0;
        chk(fl, 1'b0, "R7 clear");
        chk(irq, 1'b0, "R9 no flag no irq");

        // R6: comparator activity ignored while disabled
        cmp = 1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(st, 1'b1, "R6 status held while disabled");
        end
        cmp = 0;
        tick(3);
        chk(st, 1'b1, "R6 status still held");

        // Enable, polarity 0, rise only; held level is 0, so status falls
        wr(4'b0101);
        chk(st, 1'b0, "R1 status after enable");
        tick(3);
        chk(fl, 1'b0, "R4 unqualified fall ignored");

        // R3: latency of three edges, then R4 rise sets flag
        cmp = 1;
        tick(); chk(st, 1'b0, "R3 after edge 1");
        tick(); chk(st, 1'b0, "R3 after edge 2");
        tick(); chk(st, 1'b1, "R3 R1 after edge 3");
        chk(fl, 1'b0, "R4 flag not before edge 4");
        tick(); chk(fl, 1'b1, "R4 qualified rise");
        clr = 1; tick(); clr = 0;
        chk(fl, 1'b0, "R7 clear after rise");
        cmp = 0;
        tick(5);
        chk(st, 1'b0, "R1 status low");
        chk(fl, 1'b0, "R4 fall disabled no flag");

        // R2: polarity 1 while enabled and stable
        wr(4'b1111);
        chk(st, 1'b1, "R2 inverted status");
        tick();
        chk(fl, 1'b1, "R4 R5 polarity rise sets flag");
        clr = 1; tick(); clr = 0;
        chk(fl, 1'b0, "R7 clear");

        // R8: clear coincides with a qualified edge
        wr(4'b1101);
        tick();
        clr = 1; tick(); clr = 0;
        chk(fl, 1'b0, "R7 clear after polarity fall");
        cmp = 1;
        tick(3);
        chk(st, 1'b1, "R1 status high");
        clr = 1; tick(); clr = 0;
        chk(fl, 1'b1, "R8 edge wins over clear");
        clr = 1; tick(); clr = 0;
        chk(fl, 1'b0, "R7 plain clear");

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 4) == 0) cmp = ~cmp;
            we  = (($urandom % 16) == 0);
            wd  = 4'($urandom);
            clr = (($urandom % 6) == 0);
            ie  = (($urandom % 4) != 0);
            pg  = (($urandom % 4) != 0);
            gg  = (($urandom % 4) != 0);
            tick();
            chk(st, f_status(m_held, m_pol), m_pol ? "R2 random status" : "R1 random status");
            chk(fl, m_flag, "R4 random flag");
            chk(irq, f_irq(m_flag, ie, pg, gg), "R9 random irq");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule